// File: doc/BRIEF.md
# Memory Access Region Predictor

This block guesses, for every load and store entering the memory side of a wide-issue core, whether the access will land in the stack region or somewhere else. The guess lets the instruction be steered to one of two memory pipelines before its address is known. The guess comes from one of two places. When decode already knows the base-register class, that class decides the answer. Otherwise the answer comes from a small table. The table is indexed by the instruction address mixed with a context made of caller-ID bits and recent branch outcomes.

Each prediction is registered and carries the instruction's tag and the table index it used. Later, address translation finds the real region. The pipeline then sends back the saved index, the static flag, the prediction it was given and the real region. The block writes the real outcome into the table. When the guess was wrong, it raises a one-cycle reissue pulse that carries the tag. Two running counters record how many predictions were made and how many were wrong.

Top module: `region_predictor`

## Requirements
- R1: After a synchronous active-low reset, every table entry means non-stack (region 0). `pred_valid` and `mis_pulse` are low, and both counters read zero.
- R2: A branch-history register of HIST_W bits shifts `br_taken` into bit 0 on every cycle with `br_valid` high, moving older outcomes up one place and dropping the oldest. Without `br_valid` it holds its value.
- R3: The table index is `req_pc` XOR {`req_cid`, branch history}, with the caller bits in the upper positions. The history used is its value before any shift in the same cycle. The index is reported on `pred_index`.
- R4: Base class 1 (stack pointer) or 2 (frame pointer) forces the prediction to stack (1) and sets `pred_static`, whatever the table holds.
- R5: Base class 3 (global pointer) forces the prediction to non-stack (0) and sets `pred_static`, whatever the table holds.
- R6: Base class 0 takes the prediction from the table and clears `pred_static`. Every cycle with `req_valid` high produces, on the next cycle only, `pred_valid` high together with the request's tag.
- R7: A verify with `ver_static` low writes the real region into the entry at `ver_index`. A verify with `ver_static` high leaves the table unchanged.
- R8: When a request reads the same index that a verify writes in the same cycle, the request sees the newly written value.
- R9: A verify whose real region differs from `ver_pred` raises `mis_pulse` for exactly the next cycle, with `mis_tag` equal to `ver_tag`. A verify that agrees raises no pulse.
- R10: `pred_count` increases by one for each accepted request. `miss_count` increases by one for each mispredicted verify. Both wrap modulo 2^CNT_W.
- R11: With SAT=1, each entry is a 2-bit saturating counter. It starts at 0, counts up on a stack outcome, counts down otherwise, and its upper bit gives the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Prediction request |
| req_pc | input | IDX_W | Instruction address bits above the byte offset |
| req_base | input | 2 | Base class: 0 other, 1 stack ptr, 2 frame ptr, 3 global ptr |
| req_cid | input | IDX_W-HIST_W | Low word-address bits of the caller ID |
| req_tag | input | TAG_W | Instruction tag |
| br_valid | input | 1 | A branch resolved this cycle |
| br_taken | input | 1 | Outcome of that branch |
| ver_valid | input | 1 | Verify request |
| ver_index | input | IDX_W | Index saved with the instruction |
| ver_static | input | 1 | Instruction was statically classified |
| ver_pred | input | 1 | Region that was predicted |
| ver_region | input | 1 | Region found by translation |
| ver_tag | input | TAG_W | Tag of the verified instruction |
| pred_valid | output | 1 | Prediction present |
| pred_region | output | 1 | 1 stack, 0 non-stack |
| pred_static | output | 1 | Prediction came from the base class |
| pred_index | output | IDX_W | Index to save for verify |
| pred_tag | output | TAG_W | Tag of the prediction |
| mis_pulse | output | 1 | Reissue request |
| mis_tag | output | TAG_W | Tag to reissue |
| pred_count | output | CNT_W | Requests made |
| miss_count | output | CNT_W | Mispredictions seen |

## Verification
The hardest case to reach is a prediction that reads an entry a verify writes in the same cycle. The request index depends on the live branch history and on the caller bits, so the stimulus has to aim at it. The bench keeps its own copy of the history. From that copy it computes the address that maps onto a chosen entry, and it drives that request together with the verify. The same targeting walks a single entry through the 2-bit counter states 0 to 3 and back to 2. This exposes the point where the 1-bit and counter variants disagree.

// File: rtl/mrp_pkg.sv
// Shared types for the region predictor.
package mrp_pkg;
    // Base-register class delivered by decode.
    typedef enum logic [1:0] {
        BASE_OTHER = 2'd0,
        BASE_SP    = 2'd1,
        BASE_FP    = 2'd2,
        BASE_GP    = 2'd3
    } base_cls_e;
endpackage

// File: rtl/mrp_history.sv
// Global branch-history shift register.
// Assumes HIST_W >= 2; the newest outcome sits in bit 0.
module mrp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              br_taken,
    output logic [HIST_W-1:0] ghist
);
    // Shift the resolved outcome in; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ghist <= '0;
        else if (br_valid) ghist <= {ghist[HIST_W-2:0], br_taken};
    end

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> ghist[0] == $past(br_taken));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> $stable(ghist));
endmodule

// File: rtl/mrp_index.sv
// Index hash: the address bits XOR the caller bits concatenated with the history.
// Assumes the caller bits plus the history fill exactly IDX_W bits.
module mrp_index #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 4,
    localparam int CID_BITS = IDX_W - HIST_W
) (
    input  logic [IDX_W-1:0]    pc_bits,
    input  logic [CID_BITS-1:0] cid_bits,
    input  logic [HIST_W-1:0]   ghist,
    output logic [IDX_W-1:0]    index
);
    // Combine the address with the hybrid context.
    always_comb index = pc_bits ^ {cid_bits, ghist};
endmodule

// File: rtl/mrp_table.sv
// Region table: one entry per index, either a last-outcome bit or a 2-bit
// saturating counter (SAT=1). The read returns the value being written in the
// same cycle when the indices match. Assumes at most one write per cycle.
module mrp_table #(
    parameter int IDX_W = 6,
    parameter bit SAT   = 1'b0,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int CW      = SAT ? 2 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_region
);
    logic [CW-1:0] mem [ENTRIES];
    logic [CW-1:0] wr_cur;
    logic [CW-1:0] wr_next;
    logic [CW-1:0] rd_cur;

    always_comb wr_cur = mem[wr_idx];

    generate
        if (SAT) begin : g_sat
            // Saturating step toward the observed region.
            always_comb begin
                if (wr_region) wr_next = (wr_cur == 2'd3) ? wr_cur : wr_cur + 2'd1;
                else           wr_next = (wr_cur == 2'd0) ? wr_cur : wr_cur - 2'd1;
            end
        end else begin : g_bit
            // Remember the last observed region.
            always_comb wr_next = wr_region;
        end
    endgenerate

    // Read with bypass of a same-cycle write.
    always_comb begin
        rd_cur = mem[rd_idx];
        if (wr_en && (wr_idx == rd_idx)) rd_cur = wr_next;
        rd_bit = rd_cur[CW-1];
    end

    // Clear every entry on reset, otherwise apply the update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_next;
        end
    end
endmodule

// File: rtl/region_predictor.sv
// Top of the region predictor. It takes a request, forms the index, reads the
// table or applies the static override, and registers the result. A verify
// updates the table for dynamically predicted accesses and pulses a reissue on
// a mismatch. Assumes the pipeline returns the index and the prediction that
// were issued with the instruction.
module region_predictor
    import mrp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 4,
    parameter int TAG_W  = 4,
    parameter int CNT_W  = 16,
    parameter bit SAT    = 1'b0,
    localparam int CID_BITS = IDX_W - HIST_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [IDX_W-1:0]    req_pc,
    input  logic [1:0]          req_base,
    input  logic [CID_BITS-1:0] req_cid,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic                br_valid,
    input  logic                br_taken,
    input  logic                ver_valid,
    input  logic [IDX_W-1:0]    ver_index,
    input  logic                ver_static,
    input  logic                ver_pred,
    input  logic                ver_region,
    input  logic [TAG_W-1:0]    ver_tag,
    output logic                pred_valid,
    output logic                pred_region,
    output logic                pred_static,
    output logic [IDX_W-1:0]    pred_index,
    output logic [TAG_W-1:0]    pred_tag,
    output logic                mis_pulse,
    output logic [TAG_W-1:0]    mis_tag,
    output logic [CNT_W-1:0]    pred_count,
    output logic [CNT_W-1:0]    miss_count
);
    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  idx;
    logic              tbl_bit;
    logic              is_static;
    logic              region_nxt;
    logic              mismatch;
    base_cls_e         cls;

    mrp_history #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid),
        .br_taken(br_taken), .ghist(ghist)
    );

    mrp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_index (
        .pc_bits(req_pc), .cid_bits(req_cid), .ghist(ghist), .index(idx)
    );

    mrp_table #(.IDX_W(IDX_W), .SAT(SAT)) u_table (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_bit(tbl_bit),
        .wr_en(ver_valid && !ver_static), .wr_idx(ver_index),
        .wr_region(ver_region)
    );

    // Static override by base class, else the table.
    always_comb begin
        cls = base_cls_e'(req_base);
        is_static = (cls != BASE_OTHER);
        case (cls)
            BASE_SP, BASE_FP: region_nxt = 1'b1;
            BASE_GP:          region_nxt = 1'b0;
            default:          region_nxt = tbl_bit;
        endcase
        mismatch = ver_valid && (ver_region != ver_pred);
    end

    // Register the prediction with its tag and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_region <= 1'b0;
            pred_static <= 1'b0;
            pred_index  <= '0;
            pred_tag    <= '0;
        end else begin
            pred_valid <= req_valid;
            if (req_valid) begin
                pred_region <= region_nxt;
                pred_static <= is_static;
                pred_index  <= idx;
                pred_tag    <= req_tag;
            end
        end
    end

    // Reissue pulse and the two running counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_pulse  <= 1'b0;
            mis_tag    <= '0;
            pred_count <= '0;
            miss_count <= '0;
        end else begin
            mis_pulse <= mismatch;
            if (mismatch) begin
                mis_tag    <= ver_tag;
                miss_count <= miss_count + CNT_W'(1);
            end
            if (req_valid) pred_count <= pred_count + CNT_W'(1);
        end
    end

    a_r4_sp_fp_stack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_base == 2'd1 || req_base == 2'd2) |=> pred_region && pred_static);
    a_r5_gp_nonstack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_base == 2'd3) |=> !pred_region && pred_static);
    a_r6_valid_tag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pred_valid && pred_tag == $past(req_tag));
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pred_valid);
    a_r9_mis_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ver_valid && (ver_region != ver_pred) |=> mis_pulse && mis_tag == $past(ver_tag));
    a_r9_no_false: assert property (@(posedge clk) disable iff (!rst_n)
        !(ver_valid && (ver_region != ver_pred)) |=> !mis_pulse);
    a_r10_miss_count: assert property (@(posedge clk) disable iff (!rst_n)
        mis_pulse |-> miss_count == CNT_W'($past(miss_count) + CNT_W'(1)));
endmodule

// File: tb/region_predictor_bench.sv
// Scoreboard bench: the driver models both table variants and queues the
// expected outputs of each cycle; the monitor compares them after each edge.
// Requirements covered: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11.
module region_predictor_bench;
    typedef struct packed {
        logic       pv;
        logic       r1;
        logic       r2;
        logic [5:0] idx;
        logic [3:0] tag;
        logic       st;
        logic       mis;
        logic [3:0] mtag;
        logic [15:0] pc;
        logic [15:0] mc;
        logic [7:0] rq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, ver_valid = 0, ver_static = 0, ver_pred = 0, ver_region = 0;
    logic br_valid = 0, br_taken = 0;
    logic [5:0] req_pc = 0, ver_index = 0;
    logic [1:0] req_base = 0, req_cid = 0;
    logic [3:0] req_tag = 0, ver_tag = 0;

    logic pv_a, pr_a, ps_a, mp_a, pv_b, pr_b, ps_b, mp_b;
    logic [5:0] pi_a, pi_b;
    logic [3:0] pt_a, mt_a, pt_b, mt_b;
    logic [15:0] pc_a, mc_a, pc_b, mc_b;

    int tests = 0, fails = 0;
    bit done = 0;
    exp_t q[$];
    bit m1 [64];
    logic [1:0] m2 [64];
    logic [3:0] gh = 0;
    logic [15:0] pcnt = 0, mcnt = 0;

    always #4 clk = ~clk;

    region_predictor u_region_predictor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_base(req_base), .req_cid(req_cid), .req_tag(req_tag),
        .br_valid(br_valid), .br_taken(br_taken), .ver_valid(ver_valid),
        .ver_index(ver_index), .ver_static(ver_static), .ver_pred(ver_pred),
        .ver_region(ver_region), .ver_tag(ver_tag), .pred_valid(pv_a),
        .pred_region(pr_a), .pred_static(ps_a), .pred_index(pi_a),
        .pred_tag(pt_a), .mis_pulse(mp_a), .mis_tag(mt_a),
        .pred_count(pc_a), .miss_count(mc_a));

    region_predictor #(.SAT(1'b1)) u_region_predictor_sat (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_base(req_base), .req_cid(req_cid), .req_tag(req_tag),
        .br_valid(br_valid), .br_taken(br_taken), .ver_valid(ver_valid),
        .ver_index(ver_index), .ver_static(ver_static), .ver_pred(ver_pred),
        .ver_region(ver_region), .ver_tag(ver_tag), .pred_valid(pv_b),
        .pred_region(pr_b), .pred_static(ps_b), .pred_index(pi_b),
        .pred_tag(pt_b), .mis_pulse(mp_b), .mis_tag(mt_b),
        .pred_count(pc_b), .miss_count(mc_b));

    task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Address that maps onto a given entry under the current history.
    function automatic logic [5:0] pc_for(input logic [5:0] idx, input logic [1:0] cid);
        return idx ^ {cid, gh};
    endfunction

    // Model one cycle from the driven inputs, queue the expectation, advance.
    task automatic tick(input int rq);
        exp_t e;
        logic [5:0] ix;
        ix = req_pc ^ {req_cid, gh};
        if (ver_valid && !ver_static) begin
            m1[ver_index] = ver_region;
            if (ver_region) m2[ver_index] = (m2[ver_index] == 2'd3) ? 2'd3 : m2[ver_index] + 2'd1;
            else            m2[ver_index] = (m2[ver_index] == 2'd0) ? 2'd0 : m2[ver_index] - 2'd1;
        end
        e.pv  = req_valid;
        e.idx = ix;
        e.tag = req_tag;
        e.st  = (req_base != 2'd0);
        e.r1  = (req_base == 2'd1 || req_base == 2'd2) ? 1'b1 : (req_base == 2'd3) ? 1'b0 : m1[ix];
        e.r2  = (req_base == 2'd1 || req_base == 2'd2) ? 1'b1 : (req_base == 2'd3) ? 1'b0 : m2[ix][1];
        e.mis = ver_valid && (ver_region != ver_pred);
        e.mtag = ver_tag;
        if (req_valid) pcnt = pcnt + 16'd1;
        if (e.mis) mcnt = mcnt + 16'd1;
        e.pc = pcnt;
        e.mc = mcnt;
        e.rq = 8'(rq);
        if (br_valid) gh = {gh[2:0], br_taken};
        q.push_back(e);
        @(negedge clk);
        req_valid = 0; ver_valid = 0; br_valid = 0;
    endtask

    task automatic pr(input logic [5:0] pc, input logic [1:0] base, input logic [1:0] cid, input logic [3:0] tag, input int rq);
        req_valid = 1; req_pc = pc; req_base = base; req_cid = cid; req_tag = tag;
        tick(rq);
    endtask

    task automatic set_ver(input logic [5:0] ix, input logic st, input logic pd, input logic rg, input logic [3:0] tag);
        ver_valid = 1; ver_index = ix; ver_static = st; ver_pred = pd; ver_region = rg; ver_tag = tag;
    endtask

    // Monitor: compare one queued expectation per cycle after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                int rq;
                e = q.pop_front();
                rq = int'(e.rq);
                chk("pred_valid", rq, 32'(pv_a), 32'(e.pv));
                chk("pred_valid sat", rq, 32'(pv_b), 32'(e.pv));
                if (e.pv) begin
                    chk("pred_region", rq, 32'(pr_a), 32'(e.r1));
                    chk("pred_region sat", 11, 32'(pr_b), 32'(e.r2)); // R11
                    chk("pred_index", 3, 32'(pi_a), 32'(e.idx));      // R3
                    chk("pred_static", rq, 32'(ps_a), 32'(e.st));
                    chk("pred_tag", 6, 32'(pt_a), 32'(e.tag));        // R6
                end
                chk("mis_pulse", 9, 32'(mp_a), 32'(e.mis));           // R9
                chk("mis_pulse sat", 9, 32'(mp_b), 32'(e.mis));
                if (e.mis) chk("mis_tag", 9, 32'(mt_a), 32'(e.mtag));
                chk("pred_count", 10, 32'(pc_a), 32'(e.pc));          // R10
                chk("miss_count", 10, 32'(mc_a), 32'(e.mc));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m1[i] = 0; m2[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state at the ports
        chk("reset pred_valid", 1, 32'(pv_a), 0);
        chk("reset mis_pulse", 1, 32'(mp_a), 0);
        chk("reset pred_count", 1, 32'(pc_a), 0);
        chk("reset miss_count", 1, 32'(mc_b), 0);
        @(negedge clk);
        // R1/R6: untrained entries predict non-stack
        for (int i = 0; i < 4; i++) pr(6'(i * 13), 2'd0, 2'(i), 4'(i), 1);
        // R4: stack and frame pointer force stack
        pr(6'd5, 2'd1, 2'd0, 4'd4, 4);
        pr(6'd5, 2'd2, 2'd1, 4'd5, 4);
        // R7: a static verify leaves entry 9 untouched
        set_ver(6'd9, 1'b1, 1'b1, 1'b1, 4'd6); tick(7);
        pr(pc_for(6'd9, 2'd0), 2'd0, 2'd0, 4'd7, 7);
        // R7/R9: dynamic verify mismatches and trains entry 9
        set_ver(6'd9, 1'b0, 1'b0, 1'b1, 4'd5); tick(9);
        pr(pc_for(6'd9, 2'd0), 2'd0, 2'd0, 4'd8, 7);
        set_ver(6'd9, 1'b0, 1'b1, 1'b1, 4'd2); tick(9);
        pr(pc_for(6'd9, 2'd1), 2'd0, 2'd1, 4'd9, 6);
        // R5: global pointer overrides a stack-trained entry
        pr(pc_for(6'd9, 2'd0), 2'd3, 2'd0, 4'd10, 5);
        // R11: drive entry 9 to 3, then one step down
        set_ver(6'd9, 1'b0, 1'b1, 1'b1, 4'd3); tick(11);
        set_ver(6'd9, 1'b0, 1'b1, 1'b0, 4'd12); tick(11);
        pr(pc_for(6'd9, 2'd2), 2'd0, 2'd2, 4'd11, 11);
        // R8: same-cycle write and read of entry 20
        set_ver(6'd20, 1'b0, 1'b0, 1'b1, 4'd13);
        req_valid = 1; req_pc = pc_for(6'd20, 2'd3); req_base = 2'd0; req_cid = 2'd3; req_tag = 4'd14;
        tick(8);
        // R2/R3: shift a history pattern, with a request in the same cycle as a shift
        br_valid = 1; br_taken = 1; tick(2);
        br_valid = 1; br_taken = 0; tick(2);
        br_valid = 1; br_taken = 1;
        req_valid = 1; req_pc = 6'd17; req_base = 2'd0; req_cid = 2'd1; req_tag = 4'd1;
        tick(2);
        br_valid = 1; br_taken = 1; tick(2);
        set_ver(6'd33, 1'b0, 1'b0, 1'b1, 4'd15); tick(9);
        pr(pc_for(6'd33, 2'd2), 2'd0, 2'd2, 4'd2, 3);
        pr(pc_for(6'd34, 2'd2), 2'd0, 2'd2, 4'd3, 3);
        pr(6'd33, 2'd0, 2'd1, 4'd4, 3);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule